// File: doc/BRIEF.md
# Stream Cipher Unit Sequencer

This block controls a 64-bit block-oriented stream cipher. Message words enter through an 8-entry input FIFO. Each processed word leaves through an 8-entry output FIFO. The sequencer always keeps the newest buffered word back, because software has not yet said whether that word is the final one. Software then pulses a go strobe. The unit drains the earlier words, handles the held word as the final block and keeps only the number of leading bits set in a size register. A completion flag then rises.

A 32-word, 64-bit context store supplies the keystream words. The real keystream transform is not part of this block; in its place, the word at position k of a message is XORed with context word k modulo 32. When the dump mode is set, the whole context follows the final message word into the output FIFO. Software may read the context only after completion. It may write the context only while the retain mode is set and no message is under way. FIFO misuse and illegal context access each set a sticky status bit. Each of these bits can be disabled on its own, and an interrupt output collects the enabled ones.

Top module: `stream_seq`

## Requirements
- R1: After reset, both FIFO levels are 0, `done` is 0, `err_status` is 0, `irq` is 0, `out_data` is 0 and every context word is 0.
- R2: Until go is pulsed, the unit processes every buffered input word except the newest one, which stays in the input FIFO (`in_level` stays at 1).
- R3: The word at position k of a message, counted from 0, is output as `in_data ^ ctx[k mod 32]`. Words leave in arrival order, and at most one word is processed per cycle.
- R4: After go, the held word is processed as the final block. Only its most significant `size` bits are kept and the lower bits read 0. Without dump mode, `done` is 1 from the next cycle.
- R5: `size_wr` loads the size register only with a value that is a multiple of 8 from 8 to 64. Any other value is ignored. The reset value is 64.
- R6: With dump mode set (`mode_dump`=1), context words 0 to 31, in that order, are pushed after the final message word. `done` stays 0 until the last of them has been pushed.
- R7: The context store has 32 words of 64 bits. A legal write changes the addressed word, and `ctx_rdata` shows the word at `ctx_addr` in the same cycle.
- R8: A context write is legal only while `mode_keep`=1 and no message is in progress (`done` was last set, or nothing has been processed since reset). Any other write is discarded and sets `err_status[3]`.
- R9: A context read (`ctx_re`) while `done` is 0 sets `err_status[4]`. The data is still returned.
- R10: A push while the input FIFO holds 8 words is discarded and sets `err_status[1]`. The level never exceeds 8.
- R11: A pop of an empty output FIFO returns 0, leaves both levels unchanged and sets `err_status[2]`.
- R12: If the input FIFO is not empty in the cycle in which `done` is set, `err_status[0]` is set.
- R13: Error bits are sticky and are cleared by writing 1 through `clr_wr`/`clr_in`. A 1 in `mask_in[n]` stops error n from being recorded. `irq` is the OR of the status bits whose mask bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_push | input | 1 | Push `in_data` into the input FIFO |
| in_data | input | 64 | Message word |
| in_level | output | 4 | Input FIFO occupancy |
| out_pop | input | 1 | Pop the output FIFO head |
| out_data | output | 64 | Output FIFO head, 0 when empty |
| out_level | output | 4 | Output FIFO occupancy |
| go | input | 1 | End-of-data strobe |
| size_wr | input | 1 | Load the final-block bit count |
| size_in | input | 7 | Final-block bit count |
| mode_wr | input | 1 | Load the mode bits |
| mode_dump | input | 1 | Dump the context after the final word |
| mode_keep | input | 1 | Retain mode, allows context writes |
| mask_wr | input | 1 | Load the error disable mask |
| mask_in | input | 5 | Disable bits: 0 leftover, 1 overflow, 2 underflow, 3 context write, 4 context read |
| clr_wr | input | 1 | Write-1-to-clear strobe |
| clr_in | input | 5 | Status bits to clear |
| err_status | output | 5 | Sticky error bits |
| irq | output | 1 | Interrupt |
| ctx_we | input | 1 | Context write |
| ctx_re | input | 1 | Context read |
| ctx_addr | input | 5 | Context word index |
| ctx_wdata | input | 64 | Context write data |
| ctx_rdata | output | 64 | Context read data |
| done | output | 1 | Final block (and dump) complete |

## Verification
The main path is first run with an all-zero context, so that ordering and the held-back word show up apart from any keystream effect. It is then run with written context words and a 24-bit size, which exposes a wrong keystream index or a wrong trim mask. A burst of 20 back-to-back pushes against a stalled output shows whether the unit overflows, discards words or loses order. A dump run with a word pushed during the dump checks that the context follows the message and that a word left in the FIFO raises the leftover error, which a quiet input would never show.

// File: rtl/stream_seq.sv
module stream_seq #(
  parameter int DW = 64,
  parameter int FD = 8,
  parameter int CD = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_push,
  input  logic [DW-1:0]            in_data,
  output logic [$clog2(FD+1)-1:0]  in_level,
  input  logic                     out_pop,
  output logic [DW-1:0]            out_data,
  output logic [$clog2(FD+1)-1:0]  out_level,
  input  logic                     go,
  input  logic                     size_wr,
  input  logic [$clog2(DW+1)-1:0]  size_in,
  input  logic                     mode_wr,
  input  logic                     mode_dump,
  input  logic                     mode_keep,
  input  logic                     mask_wr,
  input  logic [4:0]               mask_in,
  input  logic                     clr_wr,
  input  logic [4:0]               clr_in,
  output logic [4:0]               err_status,
  output logic                     irq,
  input  logic                     ctx_we,
  input  logic                     ctx_re,
  input  logic [$clog2(CD)-1:0]    ctx_addr,
  input  logic [DW-1:0]            ctx_wdata,
  output logic [DW-1:0]            ctx_rdata,
  output logic                     done
);
  localparam int AW  = $clog2(FD);
  localparam int LW  = $clog2(FD+1);
  localparam int CAW = $clog2(CD);
  localparam int SW  = $clog2(DW+1);

  logic [DW-1:0]  ifq [FD];
  logic [DW-1:0]  ofq [FD];
  logic [DW-1:0]  ctx [CD];
  logic [AW-1:0]  ird, iwr, ord, owr;
  logic [LW-1:0]  icnt, ocnt;
  logic [SW-1:0]  dsize;
  logic [CAW-1:0] blk, dptr;
  logic [4:0]     msk, err;
  logic           dump_m, keep_m, go_pend, busy, dumping, done_q;

  function automatic logic [AW-1:0] inc_p(input logic [AW-1:0] p);
    return (p == AW'(FD-1)) ? '0 : p + AW'(1);
  endfunction

  wire ifull  = icnt == LW'(FD);
  wire ofull  = ocnt == LW'(FD);
  wire oempty = ocnt == '0;
  wire ipush  = in_push && !ifull;
  wire proc   = !dumping && !ofull &&
                ((icnt > LW'(1)) || (icnt == LW'(1) && go_pend));
  wire last   = proc && go_pend && icnt == LW'(1);
  wire dpush  = dumping && !ofull;
  wire opush  = proc || dpush;
  wire opop   = out_pop && !oempty;
  wire dlast  = dpush && dptr == CAW'(CD-1);
  wire finish = (last && !dump_m) || dlast;
  wire ctx_ok = keep_m && !busy;

  wire [DW-1:0] tmask = {DW{1'b1}} << (DW - int'(dsize));
  wire [DW-1:0] pword = (ifq[ird] ^ ctx[blk]) & (last ? tmask : {DW{1'b1}});
  wire [DW-1:0] oword = dumping ? ctx[dptr] : pword;
  wire [LW-1:0] icnt_nx = icnt + LW'(ipush) - LW'(proc);
  wire size_ok = size_in[2:0] == 3'd0 && size_in != '0 && int'(size_in) <= DW;

  wire [4:0] raise = {ctx_re && !done_q,
                      ctx_we && !ctx_ok,
                      out_pop && oempty,
                      in_push && ifull,
                      finish && icnt_nx != '0};

  assign in_level   = icnt;
  assign out_level  = ocnt;
  assign out_data   = oempty ? '0 : ofq[ord];
  assign ctx_rdata  = ctx[ctx_addr];
  assign err_status = err;
  assign irq        = |(err & ~msk);
  assign done       = done_q;

  always_ff @(posedge clk) begin
    if (ipush) ifq[iwr] <= in_data;
    if (opush) ofq[owr] <= oword;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ird <= '0; iwr <= '0; icnt <= '0;
      ord <= '0; owr <= '0; ocnt <= '0;
    end else begin
      if (ipush) iwr <= inc_p(iwr);
      if (proc)  ird <= inc_p(ird);
      icnt <= icnt_nx;
      if (opush) owr <= inc_p(owr);
      if (opop)  ord <= inc_p(ord);
      ocnt <= ocnt + LW'(opush) - LW'(opop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < CD; i++) ctx[i] <= '0;
    end else if (ctx_we && ctx_ok) begin
      ctx[ctx_addr] <= ctx_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dsize <= SW'(DW);
      dump_m <= 1'b0; keep_m <= 1'b0;
      msk <= '0; err <= '0;
    end else begin
      if (size_wr && size_ok) dsize <= size_in;
      if (mode_wr) begin
        dump_m <= mode_dump;
        keep_m <= mode_keep;
      end
      if (mask_wr) msk <= mask_in;
      err <= (err & ~(clr_wr ? clr_in : 5'd0)) | (raise & ~msk);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      go_pend <= 1'b0; busy <= 1'b0; done_q <= 1'b0;
      dumping <= 1'b0; blk <= '0; dptr <= '0;
    end else begin
      if (go) go_pend <= 1'b1;
      else if (last) go_pend <= 1'b0;
      if (finish) busy <= 1'b0;
      else if (proc) busy <= 1'b1;
      if (finish) done_q <= 1'b1;
      else if (proc) done_q <= 1'b0;
      if (last) blk <= '0;
      else if (proc) blk <= (blk == CAW'(CD-1)) ? '0 : blk + CAW'(1);
      if (last && dump_m) begin
        dumping <= 1'b1;
        dptr <= '0;
      end else if (dpush) begin
        if (dlast) dumping <= 1'b0;
        dptr <= dptr + CAW'(1);
      end
    end
  end
endmodule

module stream_seq_chk #(
  parameter int FD = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_push,
  input logic                    out_pop,
  input logic [$clog2(FD+1)-1:0] in_level,
  input logic [$clog2(FD+1)-1:0] out_level,
  input logic                    ctx_we,
  input logic                    keep_m,
  input logic [4:0]              msk,
  input logic [4:0]              err_status,
  input logic                    clr_wr,
  input logic [4:0]              clr_in
);
  localparam int LW = $clog2(FD+1);
  wire [4:0] clr_v = clr_wr ? clr_in : 5'd0;

  // R10
  in_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_level <= LW'(FD));

  // R10
  overflow_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_push && in_level == LW'(FD) && !msk[1]) |=> err_status[1]);

  // R11
  underflow_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_pop && out_level == '0 && !msk[2]) |=> err_status[2]);

  // R8
  ctx_write_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctx_we && !keep_m && !msk[3]) |=> err_status[3]);

  // R13
  sticky_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_status != 5'd0) |=>
      ((($past(err_status) & ~$past(clr_v)) & ~err_status) == 5'd0));

  // R3
  one_per_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_level < LW'(FD)) |=> (out_level <= $past(out_level) + LW'(1)));
endmodule

bind stream_seq stream_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_push(in_push), .out_pop(out_pop),
  .in_level(in_level), .out_level(out_level), .ctx_we(ctx_we),
  .keep_m(keep_m), .msk(msk), .err_status(err_status),
  .clr_wr(clr_wr), .clr_in(clr_in)
);

// File: tb/sim_stream_seq.sv
module sim_stream_seq;
  localparam int CLK_P = 10;

  logic clk = 0, rst_n = 0;
  logic in_push = 0, out_pop = 0, go = 0, size_wr = 0, mode_wr = 0;
  logic mode_dump = 0, mode_keep = 0, mask_wr = 0, clr_wr = 0;
  logic ctx_we = 0, ctx_re = 0;
  logic [63:0] in_data = 0, ctx_wdata = 0;
  logic [6:0] size_in = 0;
  logic [4:0] mask_in = 0, clr_in = 0, ctx_addr = 0;
  logic [3:0] in_level, out_level;
  logic [63:0] out_data, ctx_rdata;
  logic [4:0] err_status;
  logic irq, done;

  int n_chk = 0, n_err = 0, cyc_n = 0;
  logic [63:0] ctxm [32];
  logic [63:0] wv [20];

  always #(CLK_P/2) clk = ~clk;

  stream_seq u0 (
    .clk(clk), .rst_n(rst_n), .in_push(in_push), .in_data(in_data),
    .in_level(in_level), .out_pop(out_pop), .out_data(out_data),
    .out_level(out_level), .go(go), .size_wr(size_wr), .size_in(size_in),
    .mode_wr(mode_wr), .mode_dump(mode_dump), .mode_keep(mode_keep),
    .mask_wr(mask_wr), .mask_in(mask_in), .clr_wr(clr_wr), .clr_in(clr_in),
    .err_status(err_status), .irq(irq), .ctx_we(ctx_we), .ctx_re(ctx_re),
    .ctx_addr(ctx_addr), .ctx_wdata(ctx_wdata), .ctx_rdata(ctx_rdata),
    .done(done)
  );

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc_n++;
    if (cyc_n > 50000) begin
      n_chk++; n_err++;
      $display("FAIL watchdog act=%0d exp=<50000", cyc_n);
      summary();
    end
  end

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(logic [63:0] w);
    in_data = w; in_push = 1; tick(); in_push = 0;
  endtask

  task automatic pulse_go();
    go = 1; tick(); go = 0;
  endtask

  task automatic set_size(logic [6:0] s);
    size_in = s; size_wr = 1; tick(); size_wr = 0;
  endtask

  task automatic set_mode(logic d, logic k);
    mode_dump = d; mode_keep = k; mode_wr = 1; tick(); mode_wr = 0;
  endtask

  task automatic set_mask(logic [4:0] m);
    mask_in = m; mask_wr = 1; tick(); mask_wr = 0;
  endtask

  task automatic clear_all();
    clr_in = 5'h1f; clr_wr = 1; tick(); clr_wr = 0;
  endtask

  task automatic ctx_write(logic [4:0] a, logic [63:0] d);
    ctx_addr = a; ctx_wdata = d; ctx_we = 1; tick(); ctx_we = 0;
  endtask

  task automatic ctx_read(logic [4:0] a, output logic [63:0] d);
    ctx_addr = a; ctx_re = 1; #1; d = ctx_rdata; tick(); ctx_re = 0;
  endtask

  task automatic pop_exp(string tag, logic [63:0] exp);
    while (out_level == 0) tick();
    chk(tag, out_data, exp);
    out_pop = 1; tick(); out_pop = 0;
  endtask

  function automatic logic [63:0] mkw(int i, int s);
    return {32'hA5C3_0000 + 32'(s), 32'h1F2E_0000 + 32'(i * 7)};
  endfunction

  task automatic t_reset();
    chk("R1 in_level", 64'(in_level), 0);
    chk("R1 out_level", 64'(out_level), 0);
    chk("R1 done", 64'(done), 0);
    chk("R1 err", 64'(err_status), 0);
    chk("R1 irq", 64'(irq), 0);
    chk("R1 out_data", out_data, 0);
  endtask

  task automatic t_hold();
    for (int i = 0; i < 3; i++) push(mkw(i, 1));
    tick(4);
    chk("R2 in_level held", 64'(in_level), 1);
    chk("R2 out_level", 64'(out_level), 2);
    chk("R2 done low", 64'(done), 0);
    pop_exp("R3 word0", mkw(0, 1));
    pop_exp("R3 word1", mkw(1, 1));
    pulse_go();
    tick(2);
    chk("R4 done", 64'(done), 1);
    pop_exp("R4 final full", mkw(2, 1));
    chk("R2 in empty", 64'(in_level), 0);
  endtask

  task automatic t_ctx_rw();
    logic [63:0] d;
    set_mode(0, 1);
    for (int i = 0; i < 4; i++) begin
      ctxm[i] = 64'h0123_4567_89AB_CDEF ^ (64'(i) << (i * 12));
      ctx_write(5'(i), ctxm[i]);
    end
    ctx_read(5'd2, d);
    chk("R7 readback", d, ctxm[2]);
    ctx_read(5'd9, d);
    chk("R1 ctx zero", d, 0);
    chk("R7 no error", 64'(err_status), 0);
  endtask

  task automatic t_xor_trim();
    set_size(7'd24);
    set_size(7'd12);
    for (int i = 0; i < 3; i++) push(mkw(i, 2));
    pulse_go();
    pop_exp("R3 xor0", mkw(0, 2) ^ ctxm[0]);
    pop_exp("R3 xor1", mkw(1, 2) ^ ctxm[1]);
    pop_exp("R4 R5 trim24", (mkw(2, 2) ^ ctxm[2]) & 64'hFFFF_FF00_0000_0000);
    tick();
    chk("R4 done", 64'(done), 1);
    set_size(7'd72);
    push(mkw(5, 2));
    pulse_go();
    pop_exp("R5 size72 ignored", (mkw(5, 2) ^ ctxm[0]) & 64'hFFFF_FF00_0000_0000);
    set_size(7'd64);
  endtask

  task automatic t_ctx_err();
    logic [63:0] d;
    set_mode(0, 0);
    ctx_write(5'd5, 64'hDEAD_BEEF_0000_0005);
    chk("R8 keep clear err", 64'(err_status), 64'h08);
    ctx_read(5'd5, d);
    chk("R8 write discarded", d, 0);
    clear_all();
    chk("R13 w1c", 64'(err_status), 0);
    set_mode(0, 1);
    push(mkw(0, 3)); push(mkw(1, 3));
    tick(3);
    ctx_write(5'd6, 64'hCAFE_0000_0000_0006);
    ctx_read(5'd6, d);
    chk("R9 R8 busy errs", 64'(err_status), 64'h18);
    chk("R13 irq", 64'(irq), 1);
    pulse_go();
    pop_exp("R3 msg0", mkw(0, 3) ^ ctxm[0]);
    pop_exp("R3 msg1", mkw(1, 3) ^ ctxm[1]);
    tick();
    ctx_read(5'd6, d);
    chk("R8 busy write discarded", d, 0);
    clear_all();
  endtask

  task automatic t_underflow();
    chk("R11 empty data", out_data, 0);
    out_pop = 1; tick(); out_pop = 0;
    chk("R11 flag", 64'(err_status), 64'h04);
    chk("R11 levels", 64'({in_level, out_level}), 0);
    set_mask(5'h04);
    chk("R13 masked irq", 64'(irq), 0);
    chk("R13 status kept", 64'(err_status), 64'h04);
    clear_all();
    out_pop = 1; tick(); out_pop = 0;
    chk("R13 disabled not recorded", 64'(err_status), 0);
    set_mask(5'h00);
  endtask

  task automatic t_overflow();
    for (int i = 0; i < 20; i++) begin
      wv[i] = mkw(i, 4);
      push(wv[i]);
    end
    tick(2);
    chk("R10 in full", 64'(in_level), 8);
    chk("R10 out full", 64'(out_level), 8);
    chk("R10 flag", 64'(err_status), 64'h02);
    for (int i = 0; i < 8; i++) pop_exp("R10 R3 order", wv[i] ^ ctxm[i]);
    pulse_go();
    while (!(done && out_level == 0)) begin
      if (out_level != 0) begin
        out_pop = 1; tick(); out_pop = 0;
      end else tick();
    end
    chk("R10 in drained", 64'(in_level), 0);
    clear_all();
  endtask

  task automatic t_dump();
    set_mode(1, 1);
    push(mkw(0, 5));
    pulse_go();
    tick(2);
    push(mkw(1, 5));
    pop_exp("R6 last word", mkw(0, 5) ^ ctxm[0]);
    chk("R6 done low in dump", 64'(done), 0);
    for (int i = 0; i < 32; i++) pop_exp("R6 ctx word", ctxm[i]);
    tick();
    chk("R6 done", 64'(done), 1);
    chk("R12 leftover flag", 64'(err_status), 64'h01);
    chk("R2 extra held", 64'(in_level), 1);
    set_mode(0, 1);
    pulse_go();
    pop_exp("R4 extra final", mkw(1, 5) ^ ctxm[0]);
    clear_all();
  endtask

  initial begin
    for (int i = 0; i < 32; i++) ctxm[i] = 0;
    tick(3);
    rst_n = 1;
    tick();
    t_reset();
    t_hold();
    t_ctx_rw();
    t_xor_trim();
    t_ctx_err();
    t_underflow();
    t_overflow();
    t_dump();
    summary();
  end
endmodule